// File: doc/BRIEF.md
# Codec Control-Word Serializer

This block configures an audio codec over a three-wire control link: an active-low select, a serial clock and a data line. It assembles a 32-bit control word from separate setting inputs and shifts it out most significant bit first. The word goes out as an upper 16-bit half and then a lower 16-bit half, with one select assertion covering both halves. The settings are output attenuation per channel, output mute, input source per channel, input gain per channel, an interrupt mask and a general-purpose output bit.

After the block leaves reset it holds the codec's active-low reset line for a programmable number of divided ticks and then releases it. It then sends two frames without being asked. The codec discards the first frame after its own reset, so the second frame is the one that configures it. After that the block sends a frame only when `wr_req` is pulsed. The block samples the setting inputs in the cycle a frame starts.

The controller has six states. RST_HOLD holds the codec in reset. IDLE waits for a request. SEL drives select low before the first bit. CLK_HI drives the clock high and presents a data bit. CLK_LO drives the clock low. DESEL drives select high for the gap after a frame. The transitions are:
- RST_HOLD to SEL when the hold count expires; this frame is the dummy frame.
- IDLE to SEL when a request arrives.
- SEL to CLK_HI after one half-period.
- CLK_HI to CLK_LO after one half-period.
- CLK_LO back to CLK_HI after one half-period while bits remain.
- CLK_LO to DESEL after the 32nd bit.
- DESEL to SEL after one half-period if the frame just sent was the dummy, or if a request is pending.
- DESEL to IDLE after one half-period otherwise.

Top module: `codec_ctl_serializer`

## Requirements
- R1: The frame word has bit 31 = 0, bit 30 = `irq_mask`, bit 29 = `gp_out`, bits 28:24 = `left_atten`, bits 23:19 = `right_atten`, bit 18 = `mute`, bit 17 = `left_sel`, bit 16 = `right_sel`, bits 15:12 = `left_gain`, bits 11:8 = `right_gain`, and bits 7:0 = 0. Each attenuation and gain code step is 1.5 dB. The word carries the setting inputs as they were in the cycle the frame started.
- R2: `codec_rst_n` is low while `rst_n` is low and for RST_HOLD*CLK_DIV clock cycles after `rst_n` rises. After that it stays high. `cs_n` stays high while `codec_rst_n` is low.
- R3: After the codec reset is released, exactly two frames follow with no request. The first is the dummy frame and the second is the configuration frame. Both carry the packed word.
- R4: Each frame has exactly 32 rising edges of `sclk` while `cs_n` is low. Bits go out most significant first, so the upper half precedes the lower half.
- R5: `sclk` stays high for HALF_TICKS*CLK_DIV cycles per bit and low for the same number of cycles between bits. `sdata` changes only when `sclk` rises and stays stable while `sclk` is high.
- R6: `cs_n` falls HALF_TICKS*CLK_DIV cycles before the first `sclk` rise. It rises the same number of cycles after the last `sclk` fall. It stays high for at least that long between frames.
- R7: In IDLE, no frame starts without `wr_req`. A `wr_req` in IDLE starts a frame.
- R8: `busy` is high in every state except IDLE. It goes high in the cycle after an accepted request, and it stays high through reset hold and the post-frame gap. `cs_n` is high whenever `busy` is low.
- R9: A request made while `busy` is high is held. Any number of such requests produce one extra frame after the current one. That frame samples the settings at its own start. A request made during the start-up sequence is served by the configuration frame.
- R10: While `cs_n` is high, `sclk` and `sdata` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| left_atten | input | 5 | Left output attenuation code |
| right_atten | input | 5 | Right output attenuation code |
| mute | input | 1 | Output mute |
| left_sel | input | 1 | Left input source select |
| right_sel | input | 1 | Right input source select |
| left_gain | input | 4 | Left input gain code |
| right_gain | input | 4 | Right input gain code |
| irq_mask | input | 1 | Codec interrupt mask bit |
| gp_out | input | 1 | General-purpose output bit |
| wr_req | input | 1 | One-cycle write request |
| codec_rst_n | output | 1 | Active-low codec reset |
| cs_n | output | 1 | Active-low control select |
| sclk | output | 1 | Control serial clock |
| sdata | output | 1 | Control serial data |
| busy | output | 1 | Sequence or frame in progress |

## Verification
A wrong state or counter in this block shows at the ports within one frame. A stuck half-period counter makes a clock pulse the wrong length on the next edge of `sclk`. A bit counter that is off by one changes the number of clock edges in the frame, and the error appears at the next rise of `cs_n`. A shift register that snapshots at the wrong time or packs fields in the wrong order produces a wrong 32-bit word, which is decoded when select rises. A lost or duplicated pending flag changes the number of frames that follow a burst of requests. This shows once `busy` falls.

// File: rtl/codec_ctl_pkg.sv
`timescale 1ns/1ps
package codec_ctl_pkg;

    localparam int WORD_W = 32;
    localparam int ATT_W  = 5;
    localparam int GAIN_W = 4;
    localparam int PAD_W  = 8;

    typedef enum logic [2:0] {
        ST_RST_HOLD,
        ST_IDLE,
        ST_SEL,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_DESEL
    } ctl_state_e;

    // Field order follows the bit order of the control word, from bit 30 down to bit 8
    typedef struct packed {
        logic              irq_mask;
        logic              gp_out;
        logic [ATT_W-1:0]  left_atten;
        logic [ATT_W-1:0]  right_atten;
        logic              mute;
        logic              left_sel;
        logic              right_sel;
        logic [GAIN_W-1:0] left_gain;
        logic [GAIN_W-1:0] right_gain;
    } ctl_fields_t;

endpackage

// File: rtl/codec_ctl_tick.sv
`timescale 1ns/1ps
module codec_ctl_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV + 1) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/codec_ctl_packer.sv
`timescale 1ns/1ps
module codec_ctl_packer
    import codec_ctl_pkg::*;
(
    input  ctl_fields_t         fields,
    output logic [WORD_W-1:0]   word
);
    // Top bit fixed low, settings in the middle, low byte zero
    assign word = {1'b0, fields, {PAD_W{1'b0}}};
endmodule

// File: rtl/codec_ctl_serializer.sv
`timescale 1ns/1ps
module codec_ctl_serializer
    import codec_ctl_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int HALF_TICKS = 2,
    parameter int RST_HOLD   = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  left_atten,
    input  logic [4:0]  right_atten,
    input  logic        mute,
    input  logic        left_sel,
    input  logic        right_sel,
    input  logic [3:0]  left_gain,
    input  logic [3:0]  right_gain,
    input  logic        irq_mask,
    input  logic        gp_out,
    input  logic        wr_req,
    output logic        codec_rst_n,
    output logic        cs_n,
    output logic        sclk,
    output logic        sdata,
    output logic        busy
);
    localparam int HOLD_MAX = (RST_HOLD > HALF_TICKS) ? RST_HOLD : HALF_TICKS;
    localparam int PW       = $clog2(HOLD_MAX + 1);
    localparam int BW       = $clog2(WORD_W);

    ctl_state_e          state, nstate;
    logic [PW-1:0]       ph_cnt;
    logic [PW-1:0]       ph_lim;
    logic [BW-1:0]       bit_cnt;
    logic [WORD_W-1:0]   shreg;
    logic [WORD_W-1:0]   packed_word;
    logic                pend;
    logic                is_dummy;
    logic                tick;
    logic                phase_done;
    logic                last_bit;
    logic                start;
    ctl_fields_t         fields;

    assign fields = '{irq_mask:    irq_mask,
                      gp_out:      gp_out,
                      left_atten:  left_atten,
                      right_atten: right_atten,
                      mute:        mute,
                      left_sel:    left_sel,
                      right_sel:   right_sel,
                      left_gain:   left_gain,
                      right_gain:  right_gain};

    codec_ctl_packer packer_i (
        .fields (fields),
        .word   (packed_word)
    );

    codec_ctl_tick #(.DIV(CLK_DIV)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state == ST_IDLE),
        .tick    (tick)
    );

    assign ph_lim     = (state == ST_RST_HOLD) ? PW'(RST_HOLD - 1) : PW'(HALF_TICKS - 1);
    assign phase_done = tick && (ph_cnt == ph_lim);
    assign last_bit   = (bit_cnt == BW'(WORD_W - 1));
    assign start      = (nstate == ST_SEL) && (state != ST_SEL);

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_RST_HOLD: if (phase_done) nstate = ST_SEL;
            ST_IDLE:     if (wr_req)     nstate = ST_SEL;
            ST_SEL:      if (phase_done) nstate = ST_CLK_HI;
            ST_CLK_HI:   if (phase_done) nstate = ST_CLK_LO;
            ST_CLK_LO:   if (phase_done) nstate = last_bit ? ST_DESEL : ST_CLK_HI;
            ST_DESEL:    if (phase_done) nstate = (is_dummy || pend || wr_req) ? ST_SEL : ST_IDLE;
            default:     nstate = ST_RST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RST_HOLD;
        else        state <= nstate;
    end

    // Phase, bit and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cnt   <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            pend     <= 1'b0;
            is_dummy <= 1'b1;
        end else begin
            if (phase_done || state == ST_IDLE) ph_cnt <= '0;
            else if (tick)                      ph_cnt <= ph_cnt + 1'b1;

            if (start)       pend <= 1'b0;
            else if (wr_req) pend <= 1'b1;

            if (start) begin
                shreg   <= packed_word;
                bit_cnt <= '0;
                if (state != ST_RST_HOLD) is_dummy <= 1'b0;
            end else if (state == ST_CLK_LO && phase_done) begin
                shreg   <= {shreg[WORD_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        codec_rst_n = (state != ST_RST_HOLD);
        cs_n        = 1'b1;
        sclk        = 1'b0;
        sdata       = 1'b0;
        busy        = (state != ST_IDLE);
        unique case (state)
            ST_SEL:    cs_n = 1'b0;
            ST_CLK_HI: begin cs_n = 1'b0; sclk = 1'b1; sdata = shreg[WORD_W-1]; end
            ST_CLK_LO: begin cs_n = 1'b0; sdata = shreg[WORD_W-1]; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/codec_ctl_chk.sv
`timescale 1ns/1ps
module codec_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic codec_rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdata,
    input logic busy
);
    logic       prev_cs;
    logic       prev_sclk;
    logic [6:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cs   <= 1'b1;
            prev_sclk <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            prev_cs   <= cs_n;
            prev_sclk <= sclk;
            if (!cs_n && prev_cs)      rise_cnt <= '0;
            else if (sclk && !prev_sclk) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R10
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && !sdata));

    // R2
    no_sel_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !codec_rst_n |-> cs_n);

    // R2
    release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(codec_rst_n) |-> codec_rst_n);

    // R5
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !prev_cs) |-> (rise_cnt == 7'd32));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && codec_rst_n));
endmodule

bind codec_ctl_serializer codec_ctl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .codec_rst_n (codec_rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .sdata       (sdata),
    .busy        (busy)
);

// File: tb/codec_ctl_serializer_tb.sv
`timescale 1ns/1ps
module codec_ctl_serializer_tb_top;
    import codec_ctl_pkg::*;

    localparam int CLK_DIV    = 3;
    localparam int HALF_TICKS = 2;
    localparam int RST_HOLD   = 40;
    localparam int HALF_CYC   = CLK_DIV * HALF_TICKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0;
    ctl_fields_t f;
    logic codec_rst_n, cs_n, sclk, sdata, busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    codec_ctl_serializer #(
        .CLK_DIV(CLK_DIV), .HALF_TICKS(HALF_TICKS), .RST_HOLD(RST_HOLD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .left_atten(f.left_atten), .right_atten(f.right_atten),
        .mute(f.mute), .left_sel(f.left_sel), .right_sel(f.right_sel),
        .left_gain(f.left_gain), .right_gain(f.right_gain),
        .irq_mask(f.irq_mask), .gp_out(f.gp_out), .wr_req(wr_req),
        .codec_rst_n(codec_rst_n), .cs_n(cs_n), .sclk(sclk),
        .sdata(sdata), .busy(busy)
    );

    function automatic logic [31:0] pack(input ctl_fields_t v);
        logic [31:0] w;
        w        = '0;
        w[30]    = v.irq_mask;
        w[29]    = v.gp_out;
        w[28:24] = v.left_atten;
        w[23:19] = v.right_atten;
        w[18]    = v.mute;
        w[17]    = v.left_sel;
        w[16]    = v.right_sel;
        w[15:12] = v.left_gain;
        w[11:8]  = v.right_gain;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Port monitor: decodes frames and timing at the falling clock edge
    logic [31:0] flog [0:127];
    int nframes = 0;
    logic [31:0] prev_exp = '0, fexp = '0, word = '0;
    int bitc = 0, sclk_run = 0, cs_run = 0;
    logic pcs = 1'b1, psclk = 1'b0, psdata = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pcs && !cs_n) begin
                if (nframes > 0) chk(cs_run >= HALF_CYC, "R6", "gap between frames", cs_run, HALF_CYC);
                fexp = prev_exp;
                bitc = 0;
                word = '0;
            end
            if (sclk && !psclk) begin
                if (bitc == 0) chk(cs_run == HALF_CYC, "R6", "select setup", cs_run, HALF_CYC);
                else           chk(sclk_run == HALF_CYC, "R5", "clock low time", sclk_run, HALF_CYC);
                word = {word[30:0], sdata};
                bitc++;
            end
            if (!sclk && psclk) chk(sclk_run == HALF_CYC, "R5", "clock high time", sclk_run, HALF_CYC);
            if (sclk && psclk)  chk(sdata == psdata, "R5", "data stable while high", sdata, psdata);
            if (!pcs && cs_n) begin
                chk(bitc == 32, "R4", "bits per frame", bitc, 32);
                chk(sclk_run == HALF_CYC, "R6", "select hold", sclk_run, HALF_CYC);
                chk(word == fexp, "R1", "frame word", word, fexp);
                if (nframes < 128) flog[nframes] = word;
                nframes++;
            end
            if (cs_n) chk(!sclk && !sdata, "R10", "lines low while deselected", {sclk, sdata}, 0);
            if (!codec_rst_n) chk(cs_n, "R2", "select high in codec reset", cs_n, 1);
            if (sclk != psclk) sclk_run = 1; else sclk_run++;
            if (cs_n != pcs)   cs_run = 1;   else cs_run++;
            pcs = cs_n; psclk = sclk; psdata = sdata;
        end
        prev_exp = pack(f);
    end

    task automatic pulse_req();
        @(posedge clk); #1 wr_req = 1'b1;
        @(posedge clk); #1 wr_req = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic write_and_check(input ctl_fields_t v, input logic [31:0] exp, input string req);
        int n0;
        f = v;
        n0 = nframes;
        pulse_req();
        @(negedge clk);
        chk(busy, "R8", "busy after request", busy, 1);
        wait_idle();
        chk(nframes == n0 + 1, "R7", "one frame per request", nframes, n0 + 1);
        chk(flog[n0] == exp, req, "written word", flog[n0], exp);
        chk(cs_n && !busy, "R8", "idle after frame", {cs_n, busy}, 2);
    endtask

    function automatic ctl_fields_t rand_fields();
        ctl_fields_t v;
        v.irq_mask    = 1'($urandom);
        v.gp_out      = 1'($urandom);
        v.left_atten  = 5'($urandom);
        v.right_atten = 5'($urandom);
        v.mute        = 1'($urandom);
        v.left_sel    = 1'($urandom);
        v.right_sel   = 1'($urandom);
        v.left_gain   = 4'($urandom);
        v.right_gain  = 4'($urandom);
        return v;
    endfunction

    initial begin
        ctl_fields_t a, b, init_f;
        int n, n0;
        void'($urandom(32'h0C0DEC21));
        init_f = '{irq_mask: 1'b0, gp_out: 1'b1, left_atten: 5'd3, right_atten: 5'd17,
                   mute: 1'b0, left_sel: 1'b1, right_sel: 1'b0, left_gain: 4'd9, right_gain: 4'd6};
        f = init_f;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        chk(!codec_rst_n && cs_n && !sclk && busy, "R2", "reset outputs",
            {codec_rst_n, cs_n, sclk, busy}, 4'b0101);
        @(posedge clk); #1 rst_n = 1'b1;
        n = 0;
        while (!codec_rst_n && n < 10000) begin @(posedge clk); #1; n++; end
        chk(n >= RST_HOLD * CLK_DIV && n <= RST_HOLD * CLK_DIV + 1, "R2", "codec reset hold",
            n, RST_HOLD * CLK_DIV);
        // A request during start-up is served by the configuration frame (R9)
        pulse_req();
        wait_idle();
        chk(nframes == 2, "R3", "start-up frame count", nframes, 2);
        chk(flog[0] == pack(init_f), "R3", "dummy frame word", flog[0], pack(init_f));
        chk(flog[1] == pack(init_f), "R3", "config frame word", flog[1], pack(init_f));

        // R7: no frame without a request
        n0 = nframes;
        repeat (300) @(negedge clk);
        chk(nframes == n0 && !busy && cs_n, "R7", "quiet in idle", nframes, n0);

        // R1 directed field positions
        write_and_check('1, 32'h7FFF_FF00, "R1");
        write_and_check('0, 32'h0000_0000, "R1");
        a = '0; a.mute = 1'b1;       write_and_check(a, 32'h0004_0000, "R1");
        a = '0; a.left_sel = 1'b1;   write_and_check(a, 32'h0002_0000, "R1");
        a = '0; a.irq_mask = 1'b1;   write_and_check(a, 32'h4000_0000, "R1");
        a = '0; a.left_atten = 5'd31; a.right_gain = 4'd15;
        write_and_check(a, 32'h1F00_0F00, "R1");

        // R1 random settings
        for (int i = 0; i < 16; i++) begin
            a = rand_fields();
            write_and_check(a, pack(a), "R1");
        end

        // R9: requests while busy merge into one later frame with fresh settings
        a = rand_fields();
        b = rand_fields();
        b.gp_out = ~a.gp_out;
        f = a;
        n0 = nframes;
        pulse_req();
        n = 0;
        while (cs_n && n < 1000) begin @(negedge clk); n++; end
        @(posedge clk); #1 f = b;
        pulse_req();
        repeat (20) @(posedge clk);
        pulse_req();
        wait_idle();
        chk(nframes == n0 + 2, "R9", "held requests give one frame", nframes, n0 + 2);
        chk(flog[n0] == pack(a), "R9", "first frame keeps its snapshot", flog[n0], pack(a));
        chk(flog[n0 + 1] == pack(b), "R9", "held frame takes new settings", flog[n0 + 1], pack(b));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule